// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms 20-bit effective addresses for a 16-bit controller core whose address space is split into 16 pages of 64 KiB, each selected by a 4-bit page-extension field. It serves three addressing flavours. The first is a PC-relative branch target with a sign-extended byte or word offset. The second is an indexed access through index register X, after which X is advanced by a signed byte. The third is an indexed access through index register Z with an unsigned byte offset.

All 16-bit sums stay inside their page. The extension field sits above the 16-bit result and is never bumped by a carry. The Z page field and Z index live inside the unit and are loaded from dedicated vector ports during synchronous reset. Z-relative accesses can therefore reach a chosen data structure in any page from the first instruction. This stands in for a direct page, because the bottom of page 0 is taken by exception vectors. A flag marks every effective address that lands in that vector area.

The effective address, the next PC and the vector-area flag are combinational. The advanced X value is registered and changes only on a post-modify strobe.

Top module: `eag_top`

## Requirements
- R1: In relative mode (mode code 0) with the branch taken and `off_word`=0, `pc_next` equals `pc` plus `offset[7:0]` sign-extended to 16 bits, modulo 2^16.
- R2: In relative mode with the branch taken and `off_word`=1, `pc_next` equals `pc` plus the full 16-bit `offset`, modulo 2^16.
- R3: When the branch is not taken, or the mode is not relative, `pc_next` equals `pc`.
- R4: In relative mode `ea` equals {`pk`, `pc_next`}. A carry out of the 16-bit sum never changes the upper 4 bits.
- R5: In X post-modify mode (mode code 1), `ea` equals {`xk`, `ix`}, built from the current `ix` input and never from the advanced value.
- R6: `ix_new` loads `ix` plus `offset[7:0]` sign-extended, modulo 2^16, at a rising edge where `post_stb`=1 and the mode code is 1. At every other edge it holds. Reset clears it to 0.
- R7: In Z index mode (mode code 2), `ea` equals {Z page, (Z index + zero-extended `offset[7:0]`) mod 2^16}.
- R8: An edge with `rst`=1 loads the Z page from `zk_vec` and the Z index from `iz_vec`. These values then appear in `ea` in Z index mode with a zero offset.
- R9: `vec_zone` is 1 exactly when `ea` is below 0x00200.
- R10: Mode code 3 gives `ea` = {`pk`, `pc`} and `pc_next` = `pc`, and does not advance X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads Z registers from vectors |
| mode | input | 2 | 0 relative, 1 X post-modify, 2 Z index, 3 reserved |
| br_taken | input | 1 | Branch condition outcome |
| off_word | input | 1 | Relative offset width: 0 byte, 1 word |
| post_stb | input | 1 | Commit the X advance at this edge |
| offset | input | 16 | Offset; byte modes use bits 7:0 |
| pc | input | 16 | Current program counter |
| pk | input | 4 | Program page field |
| ix | input | 16 | Current index X |
| xk | input | 4 | Page field for X |
| zk_vec | input | 4 | Reset value of the Z page field |
| iz_vec | input | 16 | Reset value of the Z index |
| ea | output | 20 | Effective address |
| pc_next | output | 16 | Program counter after the branch |
| ix_new | output | 16 | Registered advanced X |
| vec_zone | output | 1 | Effective address lies in the exception-vector area |

## Verification
The Z registers have no port except the reset vectors. Their content can only be seen through `ea` in Z index mode, so the bench resets several times with different vector pairs. After each reset it probes with a zero offset and then with offsets that cross the 0x200 boundary and the 64 KiB page end. Back-to-back X post-modify accesses are the other hard case, because the advanced value must first come out of a register. The bench feeds `ix_new` back into `ix` on consecutive cycles. It checks that each address uses the value from before the advance.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int EAG_DW       = 16;
    localparam int EAG_EW       = 4;
    localparam int EAG_BW       = 8;
    localparam int EAG_VEC_SIZE = 512;

    typedef enum logic [1:0] {
        AM_REL   = 2'd0,
        AM_XPOST = 2'd1,
        AM_ZIDX  = 2'd2,
        AM_RSVD  = 2'd3
    } amode_e;

    // page-qualified address split into its two parts
    typedef struct packed {
        logic [EAG_EW-1:0] page;
        logic [EAG_DW-1:0] word;
    } paddr_t;

endpackage

// File: rtl/eag_rel_unit.sv
module eag_rel_unit #(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic [DW-1:0] pc,
    input  logic [DW-1:0] off,
    input  logic          off_word,
    input  logic          take,
    output logic [DW-1:0] pc_next
);
    localparam int PAD = DW - BW;

    logic [DW-1:0] sx_byte;
    logic [DW-1:0] delta;

    always_comb begin
        sx_byte = {{PAD{off[BW-1]}}, off[BW-1:0]};
        delta   = off_word ? off : sx_byte;
        pc_next = take ? (pc + delta) : pc;
    end
endmodule

// File: rtl/eag_xpost_unit.sv
module eag_xpost_unit #(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ix,
    input  logic [BW-1:0] off8,
    input  logic          upd,
    output logic [DW-1:0] ix_new
);
    localparam int PAD = DW - BW;

    logic [DW-1:0] step;
    assign step = {{PAD{off8[BW-1]}}, off8};

    always_ff @(posedge clk) begin
        if (rst)
            ix_new <= '0;
        else if (upd)
            ix_new <= ix + step;
    end
endmodule

// File: rtl/eag_zbase_unit.sv
module eag_zbase_unit #(
    parameter int DW = 16,
    parameter int EW = 4,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [EW-1:0] zk_vec,
    input  logic [DW-1:0] iz_vec,
    input  logic [BW-1:0] off8,
    output logic [EW-1:0] zpage,
    output logic [DW-1:0] zsum
);
    localparam int PAD = DW - BW;

    logic [DW-1:0] iz_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            zpage <= zk_vec;
            iz_q  <= iz_vec;
        end
    end

    assign zsum = iz_q + {{PAD{1'b0}}, off8};
endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
#(
    parameter int DW       = EAG_DW,
    parameter int EW       = EAG_EW,
    parameter int BW       = EAG_BW,
    parameter int VEC_SIZE = EAG_VEC_SIZE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             br_taken,
    input  logic             off_word,
    input  logic             post_stb,
    input  logic [DW-1:0]    offset,
    input  logic [DW-1:0]    pc,
    input  logic [EW-1:0]    pk,
    input  logic [DW-1:0]    ix,
    input  logic [EW-1:0]    xk,
    input  logic [EW-1:0]    zk_vec,
    input  logic [DW-1:0]    iz_vec,
    output logic [EW+DW-1:0] ea,
    output logic [DW-1:0]    pc_next,
    output logic [DW-1:0]    ix_new,
    output logic             vec_zone
);
    localparam int AW = EW + DW;
    localparam logic [AW-1:0] VEC_LIM = AW'(VEC_SIZE);

    amode_e        am;
    logic          rel_take;
    logic          x_upd;
    logic [EW-1:0] zpage;
    logic [DW-1:0] zsum;

    assign am       = amode_e'(mode);
    assign rel_take = (am == AM_REL) && br_taken;
    assign x_upd    = (am == AM_XPOST) && post_stb;

    eag_rel_unit #(.DW(DW), .BW(BW)) u_rel (
        .pc      (pc),
        .off     (offset),
        .off_word(off_word),
        .take    (rel_take),
        .pc_next (pc_next)
    );

    eag_xpost_unit #(.DW(DW), .BW(BW)) u_xpost (
        .clk   (clk),
        .rst   (rst),
        .ix    (ix),
        .off8  (offset[BW-1:0]),
        .upd   (x_upd),
        .ix_new(ix_new)
    );

    eag_zbase_unit #(.DW(DW), .EW(EW), .BW(BW)) u_zbase (
        .clk   (clk),
        .rst   (rst),
        .zk_vec(zk_vec),
        .iz_vec(iz_vec),
        .off8  (offset[BW-1:0]),
        .zpage (zpage),
        .zsum  (zsum)
    );

    always_comb begin
        unique case (am)
            AM_REL:   ea = {pk, pc_next};
            AM_XPOST: ea = {xk, ix};
            AM_ZIDX:  ea = {zpage, zsum};
            default:  ea = {pk, pc};
        endcase
    end

    assign vec_zone = (ea < VEC_LIM);
endmodule

// File: rtl/eag_checker.sv
module eag_checker
    import eag_pkg::*;
#(
    parameter int DW       = EAG_DW,
    parameter int EW       = EAG_EW,
    parameter int BW       = EAG_BW,
    parameter int VEC_SIZE = EAG_VEC_SIZE
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic             br_taken,
    input logic             post_stb,
    input logic [DW-1:0]    offset,
    input logic [DW-1:0]    pc,
    input logic [EW-1:0]    pk,
    input logic [DW-1:0]    ix,
    input logic [EW-1:0]    xk,
    input logic [EW-1:0]    zk_vec,
    input logic [DW-1:0]    iz_vec,
    input logic [EW+DW-1:0] ea,
    input logic [DW-1:0]    pc_next,
    input logic [DW-1:0]    ix_new,
    input logic             vec_zone
);
    localparam int PAD = DW - BW;
    localparam int AW  = EW + DW;

    a_r3_pc_still: assert property (@(posedge clk) disable iff (rst)
        !(mode == AM_REL && br_taken) |-> pc_next == pc);

    a_r4_page_fixed: assert property (@(posedge clk) disable iff (rst)
        mode == AM_REL |-> ea == {pk, pc_next});

    a_r5_pre_index: assert property (@(posedge clk) disable iff (rst)
        mode == AM_XPOST |-> ea == {xk, ix});

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !(post_stb && mode == AM_XPOST) |=> $stable(ix_new));

    a_r6_advance: assert property (@(posedge clk) disable iff (rst)
        (post_stb && mode == AM_XPOST) |=>
        ix_new == $past(ix) + {{PAD{$past(offset[BW-1])}}, $past(offset[BW-1:0])});

    a_r8_reload: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && mode == AM_ZIDX && offset[BW-1:0] == '0) |->
        ea == {$past(zk_vec), $past(iz_vec)});

    a_r9_zone: assert property (@(posedge clk) disable iff (rst)
        vec_zone == (ea < AW'(VEC_SIZE)));
endmodule

bind eag_top eag_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .br_taken(br_taken),
    .post_stb(post_stb),
    .offset  (offset),
    .pc      (pc),
    .pk      (pk),
    .ix      (ix),
    .xk      (xk),
    .zk_vec  (zk_vec),
    .iz_vec  (iz_vec),
    .ea      (ea),
    .pc_next (pc_next),
    .ix_new  (ix_new),
    .vec_zone(vec_zone)
);

// File: tb/tb_eag_top.sv
module tb_eag_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic        br_taken = 1'b0;
    logic        off_word = 1'b0;
    logic        post_stb = 1'b0;
    logic [15:0] offset = '0;
    logic [15:0] pc = '0;
    logic [3:0]  pk = '0;
    logic [15:0] ix = '0;
    logic [3:0]  xk = '0;
    logic [3:0]  zk_vec = '0;
    logic [15:0] iz_vec = '0;
    logic [19:0] ea;
    logic [15:0] pc_next;
    logic [15:0] ix_new;
    logic        vec_zone;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [3:0]  m_zk;
    logic [15:0] m_iz;
    logic [15:0] m_ix;

    always #2 clk = ~clk;

    eag_top dut (
        .clk(clk), .rst(rst), .mode(mode), .br_taken(br_taken),
        .off_word(off_word), .post_stb(post_stb), .offset(offset),
        .pc(pc), .pk(pk), .ix(ix), .xk(xk), .zk_vec(zk_vec),
        .iz_vec(iz_vec), .ea(ea), .pc_next(pc_next), .ix_new(ix_new),
        .vec_zone(vec_zone)
    );

    function automatic logic [15:0] exp_pcn();
        if (mode == 2'd0 && br_taken)
            return off_word ? pc + offset : pc + {{8{offset[7]}}, offset[7:0]};
        return pc;
    endfunction

    function automatic logic [19:0] exp_ea();
        case (mode)
            2'd0:    return {pk, exp_pcn()};
            2'd1:    return {xk, ix};
            2'd2:    return {m_zk, m_iz + {8'h00, offset[7:0]}};
            default: return {pk, pc};
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // called at a falling edge with inputs already driven
    task automatic step(input string req);
        logic [19:0] e;
        e = exp_ea();
        #1;
        chk(req, "ea", 32'(ea), 32'(e));
        chk(req, "pc_next", 32'(pc_next), 32'(exp_pcn()));
        chk("R9", "vec_zone", 32'(vec_zone), 32'(e < 20'h00200));
        @(posedge clk);
        if (mode == 2'd1 && post_stb)
            m_ix = ix + {{8{offset[7]}}, offset[7:0]};
        #1;
        chk("R6", "ix_new", 32'(ix_new), 32'(m_ix));
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [3:0] zv, input logic [15:0] iv);
        @(negedge clk);
        rst = 1'b1; zk_vec = zv; iz_vec = iv; post_stb = 1'b0;
        @(posedge clk);
        m_zk = zv; m_iz = iv; m_ix = '0;
        @(negedge clk);
        rst = 1'b0;
        chk("R6", "ix_new after reset", 32'(ix_new), 32'h0);
        mode = 2'd2; offset = 16'h0000;
        step("R8");
    endtask

    task automatic set_rel(input logic t, input logic w, input logic [15:0] o,
                           input logic [15:0] p, input logic [3:0] k);
        mode = 2'd0; br_taken = t; off_word = w; offset = o; pc = p; pk = k;
        post_stb = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(4'h7, 16'h1234);
        do_reset(4'h0, 16'h01F0);

        // R9 boundary in Z mode
        mode = 2'd2; offset = 16'h000F; step("R7");   // 0x001FF
        offset = 16'h0010; step("R7");                // 0x00200
        // R7 wrap inside page
        do_reset(4'h3, 16'hFFF0);
        mode = 2'd2; offset = 16'h00FF; step("R7");   // 0x300EF
        offset = 16'hAB20; step("R7");                // only low byte used

        // R1 byte offsets
        set_rel(1, 0, 16'h0010, 16'h1000, 4'h2); step("R1");
        set_rel(1, 0, 16'hFF80, 16'h1000, 4'h2); step("R1");
        set_rel(1, 0, 16'h0020, 16'hFFF0, 4'h5); step("R4"); // wrap, page kept
        // R2 word offsets
        set_rel(1, 1, 16'h1234, 16'h0100, 4'h1); step("R2");
        set_rel(1, 1, 16'h8000, 16'h0100, 4'h1); step("R2");
        set_rel(1, 1, 16'h0002, 16'hFFFF, 4'hF); step("R4");
        set_rel(1, 0, 16'h0000, 16'h0000, 4'h0); step("R9");
        // R3 not taken
        set_rel(0, 1, 16'h7777, 16'h4000, 4'h3); step("R3");
        set_rel(0, 0, 16'h0080, 16'h4000, 4'h3); step("R3");

        // R5/R6 back-to-back post-modify
        mode = 2'd1; post_stb = 1'b1; xk = 4'h9; ix = 16'h1000; offset = 16'h0005;
        step("R5");
        ix = ix_new; offset = 16'h00FE; step("R5");
        ix = ix_new; offset = 16'h0080; step("R5");
        ix = 16'hFFFF; offset = 16'h0001; step("R5");
        // R6 hold: strobe in another mode, and mode 1 without strobe
        mode = 2'd0; br_taken = 1'b0; post_stb = 1'b1; offset = 16'h0040; step("R6");
        mode = 2'd1; post_stb = 1'b0; ix = 16'h2222; step("R6");
        // R10 reserved mode
        mode = 2'd3; pc = 16'h5678; pk = 4'hC; br_taken = 1'b1; post_stb = 1'b1;
        step("R10");
        pc = 16'h0010; pk = 4'h0; step("R10");

        // random mix
        for (int i = 0; i < 400; i++) begin
            mode     = 2'($urandom % 4);
            br_taken = 1'($urandom);
            off_word = 1'($urandom);
            post_stb = 1'($urandom);
            offset   = 16'($urandom);
            pc       = 16'($urandom);
            pk       = 4'($urandom);
            xk       = 4'($urandom);
            ix       = ($urandom % 2 == 0) ? ix_new : 16'($urandom);
            if (i % 97 == 0) begin
                do_reset(4'($urandom), 16'($urandom));
            end else begin
                case (mode)
                    2'd0:    step(off_word ? "R2" : "R1");
                    2'd1:    step("R5");
                    2'd2:    step("R7");
                    default: step("R10");
                endcase
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule